// File: doc/BRIEF.md
# Reset and Power-Mode Controller

This block decides when an 8-bit microcontroller core is in reset and which of its clocks run. It takes the raw oscillator clock and the unsynchronised reset pin. The pin must stay high for a full qualification window, counted in machine cycles, before the core reset asserts. The internal time base comes from a divide-by-two toggle, so the count does not depend on the duty cycle of the incoming clock. While the core reset is active, the block also captures the level on the program-memory select pin and holds it from then on.

After reset, the CPU controls a small power-control register. Setting its idle bit stops the CPU clock while the peripherals keep running. Setting its power-down bit also stops the peripherals and, one cycle later, the oscillator. In each low-power mode the block forces the address-latch strobe and the program-fetch strobe to a fixed level. It also tells the pad logic whether port 0 should float and whether port 2 should drive its own latch instead of the address high byte. An enabled, pending interrupt wakes the core from idle. Only a qualified hardware reset ends power-down.

Top module: `rst_pwr_ctrl`

## Requirements
- R1: `core_rst` rises only after the synchronised reset pin has stayed high for 12 divided-clock ticks (24 oscillator periods). A pin pulse of 20 oscillator cycles or fewer never asserts it. A pin held high asserts it within 27 oscillator cycles.
- R2: `core_rst` is high while the synchronous power-on `rst` input is high. It falls on the third rising edge after the pin goes low, and not before.
- R3: `ea_int` follows `ea_pin` (1 = internal program memory) while the core is in reset or `rst` is high. After that it keeps its value whatever `ea_pin` does.
- R4: `pcon_q` reads 0x00 after reset, and bits 6:4 always read 0. Bit 1 is power-down, bit 0 is idle, and bits 7, 3 and 2 are general flags. A write on `pcon_wr` takes effect only while `cpu_clk_en` is high and `core_rst` is low.
- R5: If one write sets both bit 1 and bit 0, the block enters power-down and `pcon_q` reads bit 0 as 0.
- R6: In idle, `cpu_clk_en` is 0, while `per_clk_en` and `osc_run` stay 1.
- R7: In idle, a high `irq_pend` returns the block to run at the next edge. Bit 0 clears and `cpu_clk_en` goes back to 1.
- R8: In power-down, `cpu_clk_en` and `per_clk_en` are 0 and `osc_run` falls one cycle later. `irq_pend` has no effect. Only a qualified reset, with the count running once the pin restarts the oscillator, returns the block to run.
- R9: Both strobe overrides (`ale_frc_en`, `psen_frc_en`) are 1 in either low-power mode and 0 in run. The forced value (`ale_frc_val`, `psen_frc_val`) is 1 in idle and 0 in power-down.
- R10: `p0_float` is 1 in either low-power mode when `ea_int` is 0. `p2_use_latch` is 1 only in power-down when `ea_int` is 0. Both are 0 in run or with internal program memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| rst_pin | input | 1 | Raw asynchronous reset pin level |
| ea_pin | input | 1 | Program-memory select pin, 1 = internal |
| pcon_wr | input | 1 | Power-control register write strobe |
| pcon_wdata | input | 8 | Power-control write data |
| irq_pend | input | 1 | An enabled interrupt is pending |
| core_rst | output | 1 | Qualified reset to the core |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_run | output | 1 | Oscillator run enable |
| ea_int | output | 1 | Latched program-memory select, 1 = internal |
| pcon_q | output | 8 | Power-control register read value |
| ale_frc_en | output | 1 | Override address-latch strobe |
| ale_frc_val | output | 1 | Forced address-latch strobe level |
| psen_frc_en | output | 1 | Override program-fetch strobe |
| psen_frc_val | output | 1 | Forced program-fetch strobe level |
| p0_float | output | 1 | Tri-state port 0 |
| p2_use_latch | output | 1 | Port 2 drives its latch, not the address |

## Verification
On every cycle, the assertions check the following:
- A reset rise is preceded by a long enough stretch of synchronised pin high.
- The select flag is frozen outside reset.
- Idle wakes on a pending interrupt.
- Power-down holds against interrupts and stops the oscillator.
- A double-bit write lands in power-down.
- The divider only toggles while the oscillator runs.

Only the bench scenarios can show the rest: the exact windows in which a short or long pin pulse does or does not assert reset, the release latency, the readback values of the register, and the pad override pattern for each combination of mode and memory select. The bench also shows that a reset from power-down completes.

// File: rtl/rpc_pkg.sv
package rpc_pkg;
  // Power-control bit positions; software decodes these.
  localparam int unsigned PC_PD_BIT  = 1;
  localparam int unsigned PC_IDL_BIT = 0;

  typedef enum logic [1:0] {
    MODE_RUN   = 2'd0,
    MODE_IDLE  = 2'd1,
    MODE_PDOWN = 2'd2
  } pmode_e;
endpackage

// File: rtl/rpc_clk_div.sv
module rpc_clk_div (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  logic phase;

  always_ff @(posedge clk) begin
    if (rst)      phase <= 1'b0;
    else if (run) phase <= ~phase;
  end

  assign tick = phase & run;

  // R1
  div_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    run |=> (phase != $past(phase)));

  // R8
  div_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> $stable(phase));
endmodule

// File: rtl/rpc_rst_qual.sv
module rpc_rst_qual #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned HOLD_TICKS  = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic rst_pin,
  input  logic tick,
  output logic rst_req,
  output logic core_rst
);
  localparam int unsigned CNT_W  = $clog2(HOLD_TICKS);
  localparam int unsigned HI_MAX = 2 * HOLD_TICKS;
  localparam int unsigned HI_W   = $clog2(HI_MAX + 1);

  logic [SYNC_STAGES-1:0] sync;
  logic [CNT_W-1:0]       cnt;
  logic                   core_q;
  logic                   last_tick;

  assign rst_req   = sync[SYNC_STAGES-1];
  assign last_tick = tick && (cnt == CNT_W'(HOLD_TICKS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      sync   <= '0;
      cnt    <= '0;
      core_q <= 1'b1;
    end else begin
      sync <= {sync[SYNC_STAGES-2:0], rst_pin};
      if (!rst_req)
        cnt <= '0;
      else if (tick && !last_tick)
        cnt <= cnt + 1'b1;
      core_q <= rst_req & (core_q | last_tick);
    end
  end

  assign core_rst = core_q;

  // Run length of synchronised pin-high edges, for the hold check.
  logic [HI_W-1:0] hi_cnt;
  always_ff @(posedge clk) begin
    if (rst || !rst_req)                hi_cnt <= '0;
    else if (hi_cnt != HI_W'(HI_MAX))   hi_cnt <= hi_cnt + 1'b1;
  end

  // R1
  hold_len_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(core_q) |-> (hi_cnt >= HI_W'(HI_MAX - 1)));

  // R2
  release_chk: assert property (@(posedge clk) disable iff (rst)
    !rst_req |=> !core_q);
endmodule

// File: rtl/rpc_mode_ctrl.sv
module rpc_mode_ctrl
  import rpc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       core_rst,
  input  logic       rst_req,
  input  logic       ea_pin,
  input  logic       pcon_wr,
  input  logic [7:0] pcon_wdata,
  input  logic       irq_pend,
  output pmode_e     mode,
  output logic [7:0] pcon_q,
  output logic       ea_int,
  output logic       osc_run
);
  logic [2:0] flags;
  logic       ea_q;
  logic       osc_q;
  logic       spare_unused;
  pmode_e     wr_mode;

  assign spare_unused = ^pcon_wdata[6:4];

  always_comb begin
    if (pcon_wdata[PC_PD_BIT])       wr_mode = MODE_PDOWN;
    else if (pcon_wdata[PC_IDL_BIT]) wr_mode = MODE_IDLE;
    else                             wr_mode = MODE_RUN;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode  <= MODE_RUN;
      flags <= '0;
      ea_q  <= ea_pin;
      osc_q <= 1'b1;
    end else begin
      osc_q <= !((mode == MODE_PDOWN) && !rst_req);
      if (core_rst) begin
        ea_q  <= ea_pin;
        mode  <= MODE_RUN;
        flags <= '0;
      end else begin
        unique case (mode)
          MODE_RUN: if (pcon_wr) begin
            mode  <= wr_mode;
            flags <= {pcon_wdata[7], pcon_wdata[3], pcon_wdata[2]};
          end
          MODE_IDLE: if (irq_pend) mode <= MODE_RUN;
          default: mode <= MODE_PDOWN;
        endcase
      end
    end
  end

  assign pcon_q  = {flags[2], 3'b000, flags[1], flags[0],
                    mode == MODE_PDOWN, mode == MODE_IDLE};
  assign ea_int  = ea_q;
  assign osc_run = osc_q;

  // R3
  ea_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!core_rst && $past(!core_rst)) |-> $stable(ea_q));

  // R7
  idle_wake_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_IDLE && irq_pend && !core_rst) |=> (mode == MODE_RUN));

  // R8
  pd_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_PDOWN && !core_rst) |=> (mode == MODE_PDOWN));

  // R8
  osc_stop_chk: assert property (@(posedge clk) disable iff (rst)
    $past(mode == MODE_PDOWN && !rst_req) |-> !osc_q);

  // R5
  pd_prio_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_RUN && pcon_wr && pcon_wdata[PC_PD_BIT] && !core_rst)
      |=> (mode == MODE_PDOWN));
endmodule

// File: rtl/rst_pwr_ctrl.sv
module rst_pwr_ctrl
  import rpc_pkg::*;
#(
  parameter int unsigned OSC_PER_MC  = 12,
  parameter int unsigned HOLD_MC     = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rst_pin,
  input  logic       ea_pin,
  input  logic       pcon_wr,
  input  logic [7:0] pcon_wdata,
  input  logic       irq_pend,
  output logic       core_rst,
  output logic       cpu_clk_en,
  output logic       per_clk_en,
  output logic       osc_run,
  output logic       ea_int,
  output logic [7:0] pcon_q,
  output logic       ale_frc_en,
  output logic       ale_frc_val,
  output logic       psen_frc_en,
  output logic       psen_frc_val,
  output logic       p0_float,
  output logic       p2_use_latch
);
  // Ticks of the divide-by-two clock needed to qualify a reset.
  localparam int unsigned HOLD_TICKS = (OSC_PER_MC * HOLD_MC) / 2;

  logic   tick;
  logic   rst_req;
  pmode_e mode;

  rpc_clk_div u_div (
    .clk  (clk),
    .rst  (rst),
    .run  (osc_run),
    .tick (tick)
  );

  rpc_rst_qual #(
    .SYNC_STAGES (SYNC_STAGES),
    .HOLD_TICKS  (HOLD_TICKS)
  ) u_qual (
    .clk      (clk),
    .rst      (rst),
    .rst_pin  (rst_pin),
    .tick     (tick),
    .rst_req  (rst_req),
    .core_rst (core_rst)
  );

  rpc_mode_ctrl u_mode (
    .clk        (clk),
    .rst        (rst),
    .core_rst   (core_rst),
    .rst_req    (rst_req),
    .ea_pin     (ea_pin),
    .pcon_wr    (pcon_wr),
    .pcon_wdata (pcon_wdata),
    .irq_pend   (irq_pend),
    .mode       (mode),
    .pcon_q     (pcon_q),
    .ea_int     (ea_int),
    .osc_run    (osc_run)
  );

  logic low_pwr;
  assign low_pwr      = (mode != MODE_RUN);
  assign cpu_clk_en   = !low_pwr;
  assign per_clk_en   = (mode != MODE_PDOWN);
  assign ale_frc_en   = low_pwr;
  assign ale_frc_val  = (mode == MODE_IDLE);
  assign psen_frc_en  = low_pwr;
  assign psen_frc_val = (mode == MODE_IDLE);
  assign p0_float     = low_pwr && !ea_int;
  assign p2_use_latch = (mode == MODE_PDOWN) && !ea_int;

  // R9
  frc_low_chk: assert property (@(posedge clk) disable iff (rst)
    (ale_frc_en && !ale_frc_val) |-> (!per_clk_en && !cpu_clk_en));
endmodule

// File: tb/tb_rst_pwr_ctrl.sv
`timescale 1ns/1ps
module tb_rst_pwr_ctrl;
  logic clk = 1'b0;
  logic rst, rst_pin, ea_pin, pcon_wr, irq_pend;
  logic [7:0] pcon_wdata;
  logic core_rst, cpu_clk_en, per_clk_en, osc_run, ea_int;
  logic [7:0] pcon_q;
  logic ale_frc_en, ale_frc_val, psen_frc_en, psen_frc_val, p0_float, p2_use_latch;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rst_pwr_ctrl dut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // Expected override pattern per mode: 0 run, 1 idle, 2 power-down.
  function automatic logic [7:0] exp_pads(int m, logic ext);
    logic lp = (m != 0);
    return {1'b0, lp, (m == 1), lp, (m == 1), lp & ext, (m == 2) & ext, 1'b0};
  endfunction

  function automatic logic [7:0] exp_pcon(int m, logic [2:0] f);
    return {f[2], 3'b000, f[1], f[0], m == 2, m == 1};
  endfunction

  function automatic logic [7:0] pads();
    return {1'b0, ale_frc_en, ale_frc_val, psen_frc_en, psen_frc_val,
            p0_float, p2_use_latch, 1'b0};
  endfunction

  task automatic tick_n(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic write_pcon(logic [7:0] d);
    pcon_wr = 1'b1; pcon_wdata = d;
    @(negedge clk);
    pcon_wr = 1'b0;
  endtask

  task automatic hw_reset(logic ea);
    ea_pin = ea; rst_pin = 1'b1;
    tick_n(32);
    rst_pin = 1'b0;
    tick_n(3);
  endtask

  initial begin
    int m;
    logic [2:0] fl;
    void'($urandom(32'h5EED_0042));
    rst = 1'b1; rst_pin = 0; ea_pin = 0; pcon_wr = 0; pcon_wdata = 0; irq_pend = 0;
    tick_n(3);
    check("R2 core_rst during power-on reset", core_rst, 1);
    rst = 1'b0;
    tick_n(2);
    check("R2 core_rst after power-on release", core_rst, 0);
    check("R4 pcon reset value", pcon_q, 8'h00);
    check("R6 clocks enabled in run", {cpu_clk_en, per_clk_en, osc_run}, 3'b111);
    check("R9 no overrides in run", pads(), exp_pads(0, 1'b1));
    check("R3 ea captured at power-on", ea_int, 0);

    // R1 short pulse is rejected
    rst_pin = 1'b1; tick_n(20); rst_pin = 1'b0;
    check("R1 short pulse no reset (end)", core_rst, 0);
    tick_n(4);
    check("R1 short pulse no reset (after)", core_rst, 0);

    // R1 long pulse; R3 ea sampled during reset
    ea_pin = 1'b1; rst_pin = 1'b1;
    tick_n(20);
    check("R1 no reset before 24 periods", core_rst, 0);
    tick_n(7);
    check("R1 reset after hold", core_rst, 1);
    check("R3 ea follows pin in reset", ea_int, 1);
    ea_pin = 1'b0; @(negedge clk);
    check("R3 ea follows pin in reset (low)", ea_int, 0);
    rst_pin = 1'b0;
    tick_n(2);
    check("R2 reset held two edges after pin low", core_rst, 1);
    @(negedge clk);
    check("R2 reset released third edge", core_rst, 0);
    ea_pin = 1'b1; tick_n(3);
    check("R3 ea frozen after reset", ea_int, 0);

    // R6 / R10 idle with external memory
    write_pcon(8'h01);
    check("R6 idle pcon", pcon_q, 8'h01);
    check("R6 idle clocks", {cpu_clk_en, per_clk_en, osc_run}, 3'b011);
    check("R9 R10 idle pads", pads(), exp_pads(1, 1'b1));
    write_pcon(8'h02);
    check("R4 write ignored in idle", pcon_q, 8'h01);
    irq_pend = 1'b1; @(negedge clk); irq_pend = 1'b0;
    check("R7 idle wake pcon", pcon_q, 8'h00);
    check("R7 idle wake cpu clock", cpu_clk_en, 1);

    // R5 / R8 power-down
    write_pcon(8'h03);
    check("R5 both bits give power-down", pcon_q, 8'h02);
    check("R8 pd clocks", {cpu_clk_en, per_clk_en}, 2'b00);
    check("R8 osc still on first cycle", osc_run, 1);
    @(negedge clk);
    check("R8 osc stopped", osc_run, 0);
    check("R9 R10 pd pads", pads(), exp_pads(2, 1'b1));
    irq_pend = 1'b1; tick_n(3); irq_pend = 1'b0;
    check("R8 irq ignored in pd", pcon_q, 8'h02);
    check("R8 osc stays off after irq", osc_run, 0);
    ea_pin = 1'b1; rst_pin = 1'b1; tick_n(32);
    check("R8 reset asserted from pd", core_rst, 1);
    check("R8 pd left by reset", pcon_q, 8'h00);
    check("R8 osc restarted", osc_run, 1);
    rst_pin = 1'b0; tick_n(3);
    check("R3 internal memory latched", ea_int, 1);

    // R4 flags and reserved bits
    write_pcon(8'h8C);
    check("R4 flag bits", pcon_q, 8'h8C);
    write_pcon(8'h70);
    check("R4 bits 6:4 read zero", pcon_q, 8'h00);
    write_pcon(8'h01);
    check("R10 idle internal memory pads", pads(), exp_pads(1, 1'b0));
    irq_pend = 1'b1; @(negedge clk); irq_pend = 1'b0;

    // Random phase with model
    m = 0; fl = 3'b000;
    for (int it = 0; it < 400; it++) begin
      logic w, q;
      logic [7:0] d;
      if (m == 2) begin
        pcon_wr = 0; irq_pend = 0;
        hw_reset($urandom_range(0, 1));
        m = 0; fl = 3'b000;
        check("R8 R3 random reset exit", {pcon_q, ea_int}, {8'h00, ea_pin});
      end
      w = ($urandom_range(0, 3) == 0);
      d = 8'($urandom);
      q = ($urandom_range(0, 4) == 0);
      pcon_wr = w; pcon_wdata = d; irq_pend = q;
      if (m == 0 && w) begin
        m = d[1] ? 2 : (d[0] ? 1 : 0);
        fl = {d[7], d[3], d[2]};
      end else if (m == 1 && q) begin
        m = 0;
      end
      @(negedge clk);
      check("R4 R5 R7 random pcon", pcon_q, exp_pcon(m, fl));
      check("R6 R8 random clocks", {cpu_clk_en, per_clk_en}, {m == 0, m != 2});
      check("R9 R10 random pads", pads(), exp_pads(m, !ea_int));
    end
    pcon_wr = 0; irq_pend = 0;

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule